// File: doc/BRIEF.md
# Packed-Element Register File Port

This block is a general-purpose register file in which each register can be treated as a row of packed sub-word elements. Every access names a base register, an element index and an element-width code. The block turns the index into a physical register and a lane inside it. The register step is the index divided by the number of elements per register. The lane is the remainder.

A write combines the new element with the old register contents: the lanes below it are kept, and everything above it is filled according to a per-request signed flag. Writing elements in ascending order therefore builds a packed vector. A read returns the chosen element moved down to bit 0. A separate address mode returns the whole base register plus a byte offset derived from the index, which is the form a load/store unit uses as an element address.

A view input selects a register view of the full width or of half the width. In the half-width view, narrow results are kept sign-extended across the upper half of the storage. A request whose computed register lies past the last register raises a fault. A faulting write changes nothing.

Top module: `pe_regfile`

## Requirements
- R1: The element-width code selects the element width: 0 is the full view width, 1 is 8 bits, 2 is 16 bits and 3 is 32 bits. Elements per register equal the view width (XLEN, or XLEN/2 when `narrow_view` is 1) divided by the element width.
- R2: The physical register is base + index / (elements per register). The lane is index mod (elements per register), and the lane occupies bits starting at lane × element width.
- R3: A write is registered and becomes visible on the combinational read port from the cycle after the clock edge that accepts it.
- R4: A write keeps every register bit below its lane and places the low element-width bits of `wr_data` in the lane.
- R5: Every bit above the lane takes the top bit of the element when `wr_signed` is 1, and is cleared when `wr_signed` is 0.
- R6: In the full-width view with code 0, a write stores all XLEN bits of `wr_data` and a read returns the whole register.
- R7: When `narrow_view` is 1, code 0 means 32 bits. After any write whose element width is not 32, storage bits 63..32 all equal bit 31.
- R8: A write whose physical register is NREGS or above changes no register, and raises `wr_fault` for the cycle after the accepting edge. Otherwise `wr_fault` is 0.
- R9: An element-mode read narrower than the view returns the lane shifted to bit 0 with all higher bits 0. A read whose element width equals the view width returns all XLEN bits of the register unchanged.
- R10: With `rd_addr_mode` at 1, the read returns the base register, with no register stepping, plus element width × index / 8, added at full XLEN width.
- R11: A read whose physical register (the base register in address mode) is NREGS or above sets `rd_fault` to 1 and returns 0.
- R12: After synchronous reset, `wr_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_view | input | 1 | 1 selects the half-width register view |
| wr_en | input | 1 | Write request |
| wr_base | input | $clog2(NREGS) | Write base register |
| wr_idx | input | IDX_W | Write element index |
| wr_ew | input | 2 | Write element-width code |
| wr_signed | input | 1 | 1 sign-fills above the lane, 0 zero-fills |
| wr_data | input | XLEN | Write value; the low bits form the element |
| wr_fault | output | 1 | Registered out-of-range write flag |
| rd_base | input | $clog2(NREGS) | Read base register |
| rd_idx | input | IDX_W | Read element index |
| rd_ew | input | 2 | Read element-width code |
| rd_addr_mode | input | 1 | 1 returns register plus byte offset |
| rd_data | output | XLEN | Read result |
| rd_fault | output | 1 | Out-of-range read flag |

## Verification
The assertions assume that a register is written before anything depends on its contents, and that `wr_data` and the controls hold steady through each accepting edge. The stimulus meets both conditions. It first fills every register with a full-width write. It then changes inputs only on the falling edge and compares results a quarter period after the rising edge. Random requests use indices up to 63, so faulting targets appear regularly. The bench also moves between the two views, so every code is used in both views.

// File: rtl/pe_regfile_pkg.sv
package pe_regfile_pkg;

  localparam int unsigned LOGW = 4;

  typedef enum logic [1:0] {
    EW_FULL = 2'd0,
    EW_B8   = 2'd1,
    EW_B16  = 2'd2,
    EW_B32  = 2'd3
  } ew_code_e;

  // log2 of the element width for a code; the full code follows the view
  function automatic logic [LOGW-1:0] ew_log2(input logic [1:0] code,
                                               input logic narrow,
                                               input logic [LOGW-1:0] xl);
    case (ew_code_e'(code))
      EW_B8:   return LOGW'(3);
      EW_B16:  return LOGW'(4);
      EW_B32:  return LOGW'(5);
      default: return narrow ? (xl - LOGW'(1)) : xl;
    endcase
  endfunction

endpackage

// File: rtl/pe_elem_decode.sv
module pe_elem_decode
  import pe_regfile_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 24,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned RA = $clog2(NREGS),
  localparam int unsigned XL = $clog2(XLEN)
) (
  input  logic             narrow,
  input  logic [1:0]       ew,
  input  logic [RA-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [LOGW-1:0]  bw_log,
  output logic [XL-1:0]    bit_off,
  output logic [RA-1:0]    tgt,
  output logic             fault
);
  localparam int unsigned TW = ((RA > IDX_W) ? RA : IDX_W) + 1;

  logic [LOGW-1:0]  view_log;
  logic [LOGW-1:0]  epr_log;
  logic [IDX_W-1:0] lane;
  logic [TW-1:0]    sum;

  always_comb begin
    view_log = narrow ? LOGW'(XL - 1) : LOGW'(XL);
    bw_log   = ew_log2(ew, narrow, LOGW'(XL));
    epr_log  = view_log - bw_log;
    lane     = idx & IDX_W'((32'd1 << epr_log) - 32'd1);
    sum      = TW'(base) + TW'(idx >> epr_log);
    bit_off  = XL'(lane) << bw_log;
    fault    = (sum >= TW'(NREGS));
    tgt      = RA'(sum);
  end
endmodule

// File: rtl/pe_write_merge.sv
module pe_write_merge
  import pe_regfile_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned XL   = $clog2(XLEN),
  localparam int unsigned HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_val,
  input  logic [LOGW-1:0] bw_log,
  input  logic [XL-1:0]   bit_off,
  input  logic            sext,
  input  logic            narrow,
  output logic [XLEN-1:0] merged
);
  logic [XLEN-1:0] emask;
  logic [XLEN-1:0] keep_low;
  logic [XLEN-1:0] fill;
  logic [XL-1:0]   msb_pos;
  logic            msb;

  always_comb begin
    emask    = (bw_log >= LOGW'(XL)) ? '1
             : ((XLEN'(1) << (32'd1 << bw_log)) - XLEN'(1));
    msb_pos  = XL'((32'd1 << bw_log) - 32'd1);
    msb      = new_val[msb_pos];
    keep_low = (XLEN'(1) << bit_off) - XLEN'(1);
    fill     = (sext && msb) ? ~(keep_low | (emask << bit_off)) : '0;
    merged   = (old_val & keep_low) | ((new_val & emask) << bit_off) | fill;
    if (narrow && (bw_log != LOGW'(XL - 1)))
      merged[XLEN-1:HALF] = {HALF{merged[HALF-1]}};
  end
endmodule

// File: rtl/pe_read_extract.sv
module pe_read_extract
  import pe_regfile_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned XL = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  reg_val,
  input  logic [LOGW-1:0]  bw_log,
  input  logic [XL-1:0]    bit_off,
  input  logic [IDX_W-1:0] idx,
  input  logic             narrow,
  input  logic             addr_mode,
  input  logic             fault,
  output logic [XLEN-1:0]  data
);
  logic [LOGW-1:0] view_log;
  logic [XLEN-1:0] emask;

  always_comb begin
    view_log = narrow ? LOGW'(XL - 1) : LOGW'(XL);
    emask    = (bw_log >= LOGW'(XL)) ? '1
             : ((XLEN'(1) << (32'd1 << bw_log)) - XLEN'(1));
    if (fault)
      data = '0;
    else if (addr_mode)
      data = reg_val + (XLEN'(idx) << (bw_log - LOGW'(3)));
    else if (bw_log == view_log)
      data = reg_val;
    else
      data = (reg_val >> bit_off) & emask;
  end
endmodule

// File: rtl/pe_regfile.sv
module pe_regfile
  import pe_regfile_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 24,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned RA = $clog2(NREGS),
  localparam int unsigned XL = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             narrow_view,
  input  logic             wr_en,
  input  logic [RA-1:0]    wr_base,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_ew,
  input  logic             wr_signed,
  input  logic [XLEN-1:0]  wr_data,
  output logic             wr_fault,
  input  logic [RA-1:0]    rd_base,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_ew,
  input  logic             rd_addr_mode,
  output logic [XLEN-1:0]  rd_data,
  output logic             rd_fault
);
  logic [XLEN-1:0] regs [NREGS];

  logic [LOGW-1:0] w_bwlog, r_bwlog;
  logic [XL-1:0]   w_off, r_off;
  logic [RA-1:0]   w_tgt, r_tgt, r_sel;
  logic            w_dfault, r_dfault;
  logic [XLEN-1:0] w_old, w_new, r_raw;

  pe_elem_decode #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) u_wdec (
    .narrow(narrow_view), .ew(wr_ew), .base(wr_base), .idx(wr_idx),
    .bw_log(w_bwlog), .bit_off(w_off), .tgt(w_tgt), .fault(w_dfault)
  );

  pe_elem_decode #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) u_rdec (
    .narrow(narrow_view), .ew(rd_ew), .base(rd_base), .idx(rd_idx),
    .bw_log(r_bwlog), .bit_off(r_off), .tgt(r_tgt), .fault(r_dfault)
  );

  // read side: address mode uses the base register as is
  always_comb begin
    r_sel    = rd_addr_mode ? rd_base : r_tgt;
    rd_fault = rd_addr_mode ? ({1'b0, rd_base} >= (RA+1)'(NREGS)) : r_dfault;
    r_raw    = rd_fault ? '0 : regs[r_sel];
    w_old    = w_dfault ? '0 : regs[w_tgt];
  end

  pe_read_extract #(.XLEN(XLEN), .IDX_W(IDX_W)) u_rext (
    .reg_val(r_raw), .bw_log(r_bwlog), .bit_off(r_off), .idx(rd_idx),
    .narrow(narrow_view), .addr_mode(rd_addr_mode), .fault(rd_fault),
    .data(rd_data)
  );

  pe_write_merge #(.XLEN(XLEN)) u_wmrg (
    .old_val(w_old), .new_val(wr_data), .bw_log(w_bwlog), .bit_off(w_off),
    .sext(wr_signed), .narrow(narrow_view), .merged(w_new)
  );

  always_ff @(posedge clk) begin
    if (wr_en && !w_dfault)
      regs[w_tgt] <= w_new;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_fault <= 1'b0;
    else     wr_fault <= wr_en && w_dfault;
  end

  function automatic logic [XLEN-1:0] lane_mask_f(input logic [LOGW-1:0] bl);
    return (bl >= LOGW'(XL)) ? '1 : ((XLEN'(1) << (32'd1 << bl)) - XLEN'(1));
  endfunction

  // R4: the lane holds the element after the accepting edge
  assert_lane_holds_data_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_dfault) |=>
      (((regs[$past(w_tgt)] >> $past(w_off)) & lane_mask_f($past(w_bwlog)))
        == ($past(wr_data) & lane_mask_f($past(w_bwlog)))));

  // R4: bits below the lane are untouched by the write
  assert_low_lanes_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_dfault) |=>
      (((regs[$past(w_tgt)] ^ $past(w_old))
        & ((XLEN'(1) << $past(w_off)) - XLEN'(1))) == '0));

  // R7: half view, non-32 write leaves the upper half copying bit 31
  assert_narrow_upper_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_dfault && narrow_view && (w_bwlog != LOGW'(XL - 1))) |=>
      (regs[$past(w_tgt)][XLEN-1:XLEN/2]
        == {(XLEN/2){regs[$past(w_tgt)][XLEN/2-1]}}));

  // R8: a fault flag only follows a write request
  assert_fault_from_request_R8: assert property (@(posedge clk) disable iff (rst)
    wr_fault |-> $past(wr_en));

  // R11: faulting reads return zero
  assert_fault_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rd_fault |-> (rd_data == '0));

  // R9: a narrow element read has nothing above the element width
  assert_read_upper_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_addr_mode && !rd_fault
      && (r_bwlog != (narrow_view ? LOGW'(XL - 1) : LOGW'(XL)))) |->
      ((rd_data & ~lane_mask_f(r_bwlog)) == '0));

endmodule

// File: tb/pe_regfile_test.sv
module pe_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 64;
  localparam int NREGS = 24;
  localparam int IDX_W = 6;
  localparam int RA    = $clog2(NREGS);

  logic             clk = 1'b0;
  logic             rst;
  logic             narrow_view;
  logic             wr_en;
  logic [RA-1:0]    wr_base;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_ew;
  logic             wr_signed;
  logic [XLEN-1:0]  wr_data;
  logic             wr_fault;
  logic [RA-1:0]    rd_base;
  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       rd_ew;
  logic             rd_addr_mode;
  logic [XLEN-1:0]  rd_data;
  logic             rd_fault;

  pe_regfile #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .narrow_view(narrow_view),
    .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx), .wr_ew(wr_ew),
    .wr_signed(wr_signed), .wr_data(wr_data), .wr_fault(wr_fault),
    .rd_base(rd_base), .rd_idx(rd_idx), .rd_ew(rd_ew),
    .rd_addr_mode(rd_addr_mode), .rd_data(rd_data), .rd_fault(rd_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_wr;
    logic [63:0] exp_data;
    bit          exp_fault;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] model [NREGS];
  bit          nar = 1'b0;

  function automatic int bw_log_of(int ew, bit n);
    case (ew)
      1: return 3;
      2: return 4;
      3: return 5;
      default: return n ? 5 : 6;
    endcase
  endfunction

  function automatic logic [63:0] mask_of(int bw);
    return (bw >= 64) ? '1 : ((64'd1 << bw) - 64'd1);
  endfunction

  task automatic do_write(int base, int idx, int ew, bit sgn, logic [63:0] d, string tag);
    item_t it;
    int vl, bl, el, lane, tgt, bw, off;
    logic [63:0] em, low, nv;
    @(negedge clk);
    narrow_view = nar; wr_en = 1'b1; wr_base = RA'(base); wr_idx = IDX_W'(idx);
    wr_ew = 2'(ew); wr_signed = sgn; wr_data = d;
    vl = nar ? 5 : 6; bl = bw_log_of(ew, nar); el = vl - bl;
    lane = idx % (1 << el); tgt = base + (idx >> el);
    bw = 1 << bl; off = lane * bw; em = mask_of(bw);
    it.is_wr = 1'b1; it.exp_data = '0; it.tag = tag;
    it.exp_fault = (tgt >= NREGS);
    if (!it.exp_fault) begin
      low = (64'd1 << off) - 64'd1;
      nv  = (model[tgt] & low) | ((d & em) << off);
      if (sgn && d[bw-1]) nv = nv | ~(low | (em << off));
      if (nar && bw != 32) nv[63:32] = {32{nv[31]}};
      model[tgt] = nv;
    end
    sb.push_back(it);
  endtask

  task automatic do_read(int base, int idx, int ew, bit am, string tag);
    item_t it;
    int vl, bl, el, lane, tgt, bw;
    @(negedge clk);
    narrow_view = nar; wr_en = 1'b0; rd_base = RA'(base); rd_idx = IDX_W'(idx);
    rd_ew = 2'(ew); rd_addr_mode = am;
    vl = nar ? 5 : 6; bl = bw_log_of(ew, nar); el = vl - bl;
    bw = 1 << bl;
    it.is_wr = 1'b0; it.tag = tag;
    if (am) begin
      it.exp_fault = (base >= NREGS);
      it.exp_data  = it.exp_fault ? 64'd0 : model[base] + 64'((idx * bw) / 8);
    end else begin
      lane = idx % (1 << el); tgt = base + (idx >> el);
      it.exp_fault = (tgt >= NREGS);
      if (it.exp_fault)  it.exp_data = 64'd0;
      else if (bl == vl) it.exp_data = model[tgt];
      else               it.exp_data = (model[tgt] >> (lane * bw)) & mask_of(bw);
    end
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: compares one scoreboard item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (it.is_wr) begin
          if (wr_fault !== it.exp_fault) begin
            n_bad++;
            $display("FAIL %s wr_fault actual %0b expected %0b", it.tag, wr_fault, it.exp_fault);
          end
        end else if (rd_data !== it.exp_data || rd_fault !== it.exp_fault) begin
          n_bad++;
          $display("FAIL %s read actual %h/%0b expected %h/%0b",
                   it.tag, rd_data, rd_fault, it.exp_data, it.exp_fault);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; narrow_view = 1'b0; wr_en = 1'b0; wr_base = '0; wr_idx = '0;
    wr_ew = '0; wr_signed = 1'b0; wr_data = '0; rd_base = '0; rd_idx = '0;
    rd_ew = '0; rd_addr_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    n_cmp++;
    if (wr_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 wr_fault actual %0b expected 0", wr_fault);
    end

    // R6 / R3: full-width fill and readback
    for (int i = 0; i < NREGS; i++)
      do_write(i, 0, 0, 1'b0, {32'hA5A50000 + 32'(i), 32'h0F1E2D3C ^ 32'(i * 77)}, "R6");
    for (int i = 0; i < NREGS; i++) do_read(i, 0, 0, 1'b0, "R6");

    // R2 / R4: 8-bit element into reg 2 lane 1 via base 1 index 9
    do_write(1, 9, 1, 1'b0, 64'h00000000_000000C7, "R2");
    do_read(2, 1, 1, 1'b0, "R2");
    do_read(2, 0, 0, 1'b0, "R4");
    // R5: signed fill above lane, then unsigned clears above
    do_write(3, 0, 2, 1'b1, 64'h0000_0000_0000_8001, "R5");
    do_read(3, 0, 0, 1'b0, "R5");
    do_write(4, 2, 1, 1'b0, 64'h0000_0000_0000_00F0, "R5");
    do_read(4, 0, 0, 1'b0, "R5");
    // R1: 32-bit code, index 5 -> reg 7 lane 1
    do_write(5, 5, 3, 1'b1, 64'h0000_0000_1234_5678, "R1");
    do_read(7, 1, 3, 1'b0, "R1");
    do_read(7, 0, 0, 1'b0, "R1");
    // R3: back-to-back writes to one register, then read
    do_write(8, 0, 1, 1'b0, 64'h11, "R3");
    do_write(8, 1, 1, 1'b0, 64'h22, "R3");
    do_read(8, 1, 1, 1'b0, "R3");
    do_read(8, 0, 2, 1'b0, "R3");
    // R7: half view, 16-bit top lane zero-filled still copies bit 31
    nar = 1'b1;
    do_write(9, 1, 2, 1'b0, 64'h8000, "R7");
    do_read(9, 0, 0, 1'b0, "R7");
    do_write(10, 0, 0, 1'b0, 64'h0000_0000_8765_4321, "R7");
    do_read(10, 0, 0, 1'b0, "R7");
    do_read(10, 3, 1, 1'b0, "R9");
    nar = 1'b0;
    // R8: out-of-range write changes nothing
    do_write(20, 40, 1, 1'b1, 64'hFF, "R8");
    for (int i = 20; i < NREGS; i++) do_read(i, 0, 0, 1'b0, "R8");
    // R11: faulting reads
    do_read(23, 8, 1, 1'b0, "R11");
    do_read(30, 0, 0, 1'b1, "R11");
    // R10: address mode
    do_read(4, 5, 2, 1'b1, "R10");
    do_read(6, 3, 0, 1'b1, "R10");
    nar = 1'b1;
    do_read(6, 3, 0, 1'b1, "R10");
    nar = 1'b0;
    // R9: narrow element extracts
    do_read(0, 7, 1, 1'b0, "R9");
    do_read(1, 3, 2, 1'b0, "R9");

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int op;
      op  = $urandom_range(0, 3);
      nar = 1'($urandom_range(0, 1));
      if (op < 2)
        do_write($urandom_range(0, NREGS - 1), $urandom_range(0, 63), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)), {$urandom, $urandom}, "R5");
      else
        do_read($urandom_range(0, 31), $urandom_range(0, 63), $urandom_range(0, 3),
                1'(op == 3), "R9");
    end
    nar = 1'b0;
    for (int i = 0; i < NREGS; i++) do_read(i, 0, 0, 1'b0, "R4");

    idle();
    repeat (3) @(posedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule